// File: doc/BRIEF.md
# Truncating Integer-to-Single-Precision Converter

This block turns a signed two's-complement integer into the bit pattern of an IEEE-754 single-precision number. When the integer has more significant bits than the 24-bit significand can hold, the surplus low bits are discarded, so the result always rounds toward zero. The datapath takes the absolute value of the input and shifts it left until its leading one reaches the top bit. It then keeps the upper bits as the significand, derives the biased exponent from the shift distance and attaches the sign.

Data enters on a valid/ready handshake and leaves one clock later through a single output register that obeys the same handshake. A two-state controller tracks that register. In `ST_EMPTY` the register holds nothing and input is always accepted. In `ST_FULL` it holds a result, and new input is accepted only when the consumer takes the result in the same cycle. The transitions are: `ACCEPT` (EMPTY to FULL on an accepted input), `DRAIN` (FULL to EMPTY when the result is taken and no new input arrives), `STREAM` (FULL stays FULL when a result is taken and a new input is accepted together) and `HOLD` (FULL stays FULL while the consumer stalls).

Top module: `i2f_trunc`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An input of 0 yields the pattern 0x00000000.
- R3: Exactly representable positive inputs give the exact float pattern (1 gives 0x3F800000, 12 gives 0x41400000, 16777216 gives 0x4B800000).
- R4: Inputs that are not exactly representable are truncated toward zero: 2147483647 gives 0x4EFFFFFF (value 2147483520), and 16777219 gives 0x4B800001 (value 16777218).
- R5: A negative input sets bit 31 of the result and encodes its magnitude with the same truncation: -1 gives 0xBF800000, and -2147483647 gives 0xCEFFFFFF.
- R6: The most negative input, -2147483648, gives exactly 0xCF000000.
- R7: A result appears on `out_valid`/`out_data` in the cycle after its input is accepted (`in_valid` and `in_ready` high at a clock edge).
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_valid` and `out_data` hold their values.
- R9: For arbitrary 32-bit inputs, the result equals sign, biased exponent 127+p and the 23 bits below the leading one, where p is the position of the magnitude's highest set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input integer is present |
| in_ready | output | 1 | Block can take the input this cycle |
| in_data | input | 32 | Signed two's-complement integer |
| out_valid | output | 1 | Result register holds a conversion |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Single-precision bit pattern |

## Verification
Every result is due one clock edge after its input is accepted. The bench drives inputs on a falling edge, lets exactly one rising edge capture them, and reads the output on the following falling edge. Under stall, the held pattern and the low `in_ready` are read on each falling edge while the consumer is not ready. The result of the input offered during the stall is read on the falling edge after the first rising edge at which `out_ready` is high again.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
    localparam int INT_W  = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int FLT_W  = 1 + EXP_W + MAN_W;
    localparam int SH_W   = $clog2(INT_W);
    localparam int STAGES = SH_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;
endpackage

// File: rtl/i2f_magnitude.sv
module i2f_magnitude
    import i2f_pkg::*;
(
    input  logic [INT_W-1:0] value,
    output logic [INT_W-1:0] mag,
    output logic             neg,
    output logic             nonzero
);
    always_comb begin
        neg     = value[INT_W-1];
        mag     = neg ? (~value + INT_W'(1)) : value;
        nonzero = |value;
    end
endmodule

// File: rtl/i2f_normalize.sv
module i2f_normalize
    import i2f_pkg::*;
(
    input  logic [INT_W-1:0] mag,
    output logic [INT_W-1:0] norm,
    output logic [SH_W-1:0]  shift
);
    logic [INT_W-1:0] val [0:STAGES];
    logic [SH_W-1:0]  cnt [0:STAGES];

    assign val[0] = mag;
    assign cnt[0] = '0;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int AMT = 1 << (STAGES - 1 - k);
        logic top_clear;
        always_comb begin
            top_clear  = ~|val[k][INT_W-1 -: AMT];
            val[k+1]   = top_clear ? (val[k] << AMT) : val[k];
            cnt[k+1]   = top_clear ? (cnt[k] + SH_W'(AMT)) : cnt[k];
        end
    end

    assign norm  = val[STAGES];
    assign shift = cnt[STAGES];

    always_comb begin
        if (mag != '0) begin
            AST_NORM_LEADING: assert (norm[INT_W-1]); // R9
        end
    end
endmodule

// File: rtl/i2f_pack.sv
module i2f_pack
    import i2f_pkg::*;
(
    input  logic [INT_W-1:0] norm,
    input  logic [SH_W-1:0]  shift,
    input  logic             neg,
    input  logic             nonzero,
    output logic [FLT_W-1:0] bits
);
    localparam int DROP = INT_W - MAN_W - 1;

    logic [FLT_W-1:0] mant_ext;
    logic [FLT_W-1:0] exp_term;
    logic [FLT_W-1:0] body;

    always_comb begin
        mant_ext = FLT_W'(norm >> DROP);
        exp_term = FLT_W'(BIAS + INT_W - 2) - FLT_W'(shift);
        body     = nonzero ? (mant_ext + (exp_term << MAN_W)) : '0;
        bits     = body | ({{(FLT_W-1){1'b0}}, neg} << (FLT_W - 1));
    end
endmodule

// File: rtl/i2f_trunc.sv
module i2f_trunc
    import i2f_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [INT_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [FLT_W-1:0] out_data
);
    logic [INT_W-1:0] mag;
    logic             neg;
    logic             nonzero;
    logic [INT_W-1:0] norm;
    logic [SH_W-1:0]  shift;
    logic [FLT_W-1:0] packed_bits;

    stage_e state, state_nx;
    logic   accept;
    logic   take;

    i2f_magnitude u_mag (
        .value   (in_data),
        .mag     (mag),
        .neg     (neg),
        .nonzero (nonzero)
    );

    i2f_normalize u_norm (
        .mag   (mag),
        .norm  (norm),
        .shift (shift)
    );

    i2f_pack u_pack (
        .norm    (norm),
        .shift   (shift),
        .neg     (neg),
        .nonzero (nonzero),
        .bits    (packed_bits)
    );

    always_comb begin
        in_ready  = (state == ST_EMPTY) || out_ready;
        out_valid = (state == ST_FULL);
        accept    = in_valid && in_ready;
        take      = out_valid && out_ready;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (accept) state_nx = ST_FULL;            // ACCEPT
            ST_FULL:  if (take && !accept) state_nx = ST_EMPTY;  // DRAIN; else STREAM / HOLD
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      out_data <= '0;
        else if (accept) out_data <= packed_bits;
    end

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R8
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R7
    AST_ZERO_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_data == '0 |=> out_data == '0); // R2
    AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_data[FLT_W-1] == $past(in_data[INT_W-1])); // R5
    AST_MIN_INT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_data == {1'b1, {(INT_W-1){1'b0}}}
        |=> out_data == 32'hCF00_0000); // R6
endmodule

// File: tb/i2f_trunc_bench.sv
module i2f_trunc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    i2f_trunc u_i2f_trunc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // {input, expected pattern}
    localparam logic [63:0] VEC [0:11] = '{
        {32'h0000_0000, 32'h0000_0000},   // R2
        {32'h0000_0001, 32'h3F80_0000},   // R3
        {32'h0000_000C, 32'h4140_0000},   // R3
        {32'h0100_0000, 32'h4B80_0000},   // R3
        {32'h7FFF_FFFF, 32'h4EFF_FFFF},   // R4
        {32'h0100_0003, 32'h4B80_0001},   // R4
        {32'hFFFF_FFFF, 32'hBF80_0000},   // R5
        {32'h8000_0001, 32'hCEFF_FFFF},   // R5
        {32'h8000_0000, 32'hCF00_0000},   // R6
        {32'h4000_0000, 32'h4E80_0000},   // R3
        {32'hFFFF_FFF4, 32'hC140_0000},   // R5
        {32'h00FF_FFFF, 32'h4B7F_FFFF}    // R3
    };

    function automatic logic [31:0] ref_model(input logic [31:0] x);
        logic [63:0] m;
        logic [63:0] al;
        int p;
        logic [7:0] e;
        m = x[31] ? (64'h1_0000_0000 - {32'h0, x}) : {32'h0, x};
        if (m == 0) return 32'h0;
        p = 0;
        for (int i = 0; i < 33; i++) if (m[i]) p = i;
        al = m << (31 - p);
        e  = 8'(127 + p);
        return {x[31], e, al[30:8]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic convert(input logic [31:0] x, input logic [31:0] exp, input string req);
        @(negedge clk);
        in_data  = x;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7", {31'h0, out_valid}, 32'h1);
        check(req, out_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {30'h0, out_valid, in_ready}, 32'h1);

        for (int i = 0; i < 12; i++) begin
            string tag;
            tag = (i == 0) ? "R2" : (i == 4 || i == 5) ? "R4" :
                  (i == 6 || i == 7 || i == 10) ? "R5" : (i == 8) ? "R6" : "R3";
            convert(VEC[i][63:32], VEC[i][31:0], tag);
        end

        // R7: idle after drain, no stray valid
        @(negedge clk);
        check("R7", {31'h0, out_valid}, 32'h0);

        // R8: backpressure
        out_ready = 1'b0;
        in_data   = 32'h0000_0005;
        in_valid  = 1'b1;
        @(negedge clk);
        check("R8", out_data, 32'h40A0_0000);
        in_data = 32'h0000_0003;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8", {30'h0, out_valid, in_ready}, 32'h2);
            check("R8", out_data, 32'h40A0_0000);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", out_data, 32'h4040_0000);
        check("R7", {31'h0, out_valid}, 32'h1);

        // R9: random against reference
        for (int n = 0; n < 300; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (n % 3 == 1) r = r >> (n % 31);
            convert(r, ref_model(r), "R9");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule